// File: doc/BRIEF.md
# Ethernet MAC Loopback Path and Frame Check Sequence Unit

This block sits between a byte-wide transmit frame stream from the MAC, the byte-wide network port, and the byte-wide receive stream back into the MAC. It computes the 32-bit frame check sequence for outgoing frames and appends it. A configuration bit can turn the append off, so that frames which already carry their check bytes go out unchanged. It also steers traffic through one of three paths: normal operation, internal loopback (transmit folded straight back into the receiver) or external loopback (frames go out on the wire and the receiver keeps listening to the wire).

The receive checker cannot be switched off. It runs a separate CRC engine over every incoming frame and marks the frame good or bad on its last byte. It drops frames that are too short unless short-frame acceptance is in effect. Over the six destination address bytes it produces a hash index for an external multicast filter. Any loopback mode forces short-frame acceptance on but leaves the stored configuration bit alone. A status output reports when the line coder has been selected as part of the loop.

Top module: `lpbk_fcs_ctrl`

## Requirements
- R1: While reset is held and after its release, `tx_ready` is 1 and `net_tx_valid`, `rx_valid` and `mc_hash_valid` are 0.
- R2: With `cfg_tx_fcs_dis`=0, the frame on the network transmit port is the supplied bytes followed by four check bytes, least significant byte first. The check value is the bitwise inverse of a CRC-32 (polynomial 0x04C11DB7, register preset to all ones, each byte taken bit 0 first, result bit-reflected). `tx_ready` is 0 while the check bytes are emitted.
- R3: With `cfg_tx_fcs_dis`=1, the transmitted frame is exactly the supplied bytes, with nothing appended.
- R4: On the last received byte, `rx_good` is 1 exactly when the frame's final four bytes (least significant first) equal the R2 check value computed over the bytes before them.
- R5: On the last received byte, `rx_drop` is 1 exactly when the frame holds fewer than 64 bytes, counting the check bytes, and neither `cfg_runt_acc` nor `cfg_lb_en` is 1. `rx_runt_eff` equals `cfg_runt_acc` OR `cfg_lb_en`.
- R6: In internal loopback (`cfg_lb_en`=1, `cfg_lb_int`=1), `net_tx_valid` stays 0. The receiver sees the transmitted frame, including any appended check bytes. Bytes arriving on the network receive port are ignored.
- R7: In either loopback mode, a short frame is not dropped while `cfg_runt_acc` is 0.
- R8: In external loopback (`cfg_lb_en`=1, `cfg_lb_int`=0), frames are transmitted on the network port and the receiver takes the network receive port.
- R9: When the first byte of a received frame has bit 0 set, `mc_hash_valid` pulses for one cycle after the sixth byte. `mc_hash` then equals bits 31:26 of the R2 check value computed over the first six bytes. No pulse occurs when bit 0 of the first byte is clear.
- R10: Frames of any length, including a single byte, pass through both loopback paths.
- R11: `lb_via_codec` equals `cfg_lb_en` AND `cfg_lb_codec`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_lb_en | input | 1 | Loopback enable |
| cfg_lb_int | input | 1 | 1 = internal loopback, 0 = external |
| cfg_lb_codec | input | 1 | Line coder included in the loop |
| cfg_tx_fcs_dis | input | 1 | Disable transmit check append |
| cfg_runt_acc | input | 1 | Stored short-frame accept setting |
| tx_valid | input | 1 | Transmit byte valid |
| tx_data | input | 8 | Transmit byte |
| tx_last | input | 1 | Last byte of transmit frame |
| tx_ready | output | 1 | Transmit byte accepted |
| net_tx_valid | output | 1 | Network transmit byte valid |
| net_tx_data | output | 8 | Network transmit byte |
| net_tx_last | output | 1 | Last network transmit byte |
| net_rx_valid | input | 1 | Network receive byte valid |
| net_rx_data | input | 8 | Network receive byte |
| net_rx_last | input | 1 | Last network receive byte |
| rx_valid | output | 1 | Receive byte valid to MAC |
| rx_data | output | 8 | Receive byte to MAC |
| rx_last | output | 1 | Last receive byte |
| rx_good | output | 1 | Check value correct, valid with rx_last |
| rx_drop | output | 1 | Short frame to be discarded, valid with rx_last |
| rx_runt_eff | output | 1 | Short-frame acceptance in effect |
| lb_via_codec | output | 1 | Loop passes through the line coder |
| mc_hash_valid | output | 1 | Multicast hash index valid |
| mc_hash | output | 6 | Multicast hash index |

## Verification
The hardest case to reach from the ports is internal loopback while the wire is busy. A correct receiver must ignore the network input entirely, and that shows only if both inputs carry traffic in the same cycles. The bench therefore drives a long garbage stream into the network receive port in parallel with a short transmit frame. It then requires that exactly one frame, the looped one with its appended check bytes, reaches the receive output and is not dropped as short. Single-byte frames, with the append both on and off, cover the boundary where the append sequence starts immediately after the only data byte.

// File: rtl/lbk_pkg.sv
package lbk_pkg;
  localparam int          BYTE_W       = 8;
  localparam int          FCS_BYTES    = 4;
  localparam logic [31:0] CRC_POLY_R   = 32'hEDB88320;
  localparam logic [31:0] CRC_PRESET   = 32'hFFFFFFFF;
  localparam logic [31:0] CRC_RESIDUE_R = 32'hDEBB20E3;

  typedef struct packed {
    logic              valid;
    logic [BYTE_W-1:0] data;
    logic              last;
  } beat_t;

  // Reflected CRC-32 update, one byte, bit 0 first.
  function automatic logic [31:0] crc_step(input logic [31:0] c,
                                           input logic [BYTE_W-1:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < BYTE_W; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY_R;
      else             r = r >> 1;
    end
    return r;
  endfunction

  // Check value sent on the wire, least significant byte first.
  function automatic logic [31:0] crc_final(input logic [31:0] c);
    return ~c;
  endfunction
endpackage

// File: rtl/lbk_tx_fcs.sv
module lbk_tx_fcs
  import lbk_pkg::*;
#(
  parameter int FCS_N = FCS_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fcs_dis,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_last,
  output logic              in_ready,
  output beat_t             out_beat
);
  localparam int IDX_W = (FCS_N > 1) ? $clog2(FCS_N) : 1;
  localparam logic [IDX_W-1:0] IDX_END = IDX_W'(FCS_N - 1);

  logic             app_q;
  logic [IDX_W-1:0] idx_q;
  logic [31:0]      crc_q;
  logic [31:0]      fcs_q;
  beat_t            beat_q;
  logic             accept;
  logic [31:0]      crc_nxt;

  assign in_ready = ~app_q;
  assign accept   = in_valid & ~app_q;
  assign crc_nxt  = crc_step(crc_q, in_data);
  assign out_beat = beat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      app_q  <= 1'b0;
      idx_q  <= '0;
      crc_q  <= CRC_PRESET;
      fcs_q  <= '0;
      beat_q <= '0;
    end else if (app_q) begin
      beat_q.valid <= 1'b1;
      beat_q.data  <= fcs_q[idx_q*BYTE_W +: BYTE_W];
      beat_q.last  <= (idx_q == IDX_END);
      idx_q        <= idx_q + 1'b1;
      if (idx_q == IDX_END) app_q <= 1'b0;
    end else if (accept) begin
      beat_q.valid <= 1'b1;
      beat_q.data  <= in_data;
      beat_q.last  <= in_last & fcs_dis;
      if (in_last) begin
        crc_q <= CRC_PRESET;
        fcs_q <= crc_final(crc_nxt);
        app_q <= ~fcs_dis;
        idx_q <= '0;
      end else begin
        crc_q <= crc_nxt;
      end
    end else begin
      beat_q <= '0;
    end
  end
endmodule

// File: rtl/lbk_path_sel.sv
module lbk_path_sel
  import lbk_pkg::*;
(
  input  logic  lb_en,
  input  logic  lb_int,
  input  logic  lb_codec,
  input  logic  runt_acc,
  input  beat_t tx_beat,
  input  beat_t net_rx_beat,
  output beat_t net_tx_beat,
  output beat_t rx_src_beat,
  output logic  runt_eff,
  output logic  via_codec
);
  logic int_loop;

  assign int_loop    = lb_en & lb_int;
  assign net_tx_beat = int_loop ? beat_t'('0) : tx_beat;
  assign rx_src_beat = int_loop ? tx_beat : net_rx_beat;
  assign runt_eff    = runt_acc | lb_en;
  assign via_codec   = lb_en & lb_codec;
endmodule

// File: rtl/lbk_rx_chk.sv
module lbk_rx_chk
  import lbk_pkg::*;
#(
  parameter int MIN_LEN    = 64,
  parameter int ADDR_BYTES = 6,
  parameter int HASH_W     = 6,
  parameter int LEN_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  beat_t             in_beat,
  input  logic              runt_eff,
  output beat_t             out_beat,
  output logic              good,
  output logic              drop,
  output logic              hash_valid,
  output logic [HASH_W-1:0] hash
);
  localparam logic [LEN_W-1:0] MIN_L  = LEN_W'(MIN_LEN);
  localparam logic [LEN_W-1:0] ADDR_L = LEN_W'(ADDR_BYTES);
  localparam logic [LEN_W-1:0] LEN_MAX = '1;

  logic [31:0]       crc_q;
  logic [LEN_W-1:0]  len_q;
  logic              grp_q;
  beat_t             beat_q;
  logic              good_q, drop_q, hv_q;
  logic [HASH_W-1:0] hash_q;
  logic [31:0]       crc_nxt;
  logic [31:0]       addr_fcs;
  logic [LEN_W-1:0]  len_nxt;

  assign crc_nxt  = crc_step(crc_q, in_beat.data);
  assign addr_fcs = crc_final(crc_nxt);
  assign len_nxt  = (len_q == LEN_MAX) ? len_q : len_q + 1'b1;

  assign out_beat   = beat_q;
  assign good       = good_q;
  assign drop       = drop_q;
  assign hash_valid = hv_q;
  assign hash       = hash_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crc_q  <= CRC_PRESET;
      len_q  <= '0;
      grp_q  <= 1'b0;
      beat_q <= '0;
      good_q <= 1'b0;
      drop_q <= 1'b0;
      hv_q   <= 1'b0;
      hash_q <= '0;
    end else if (in_beat.valid) begin
      beat_q <= in_beat;
      good_q <= in_beat.last & (crc_nxt == CRC_RESIDUE_R);
      drop_q <= in_beat.last & (len_nxt < MIN_L) & ~runt_eff;
      if (len_q == '0) grp_q <= in_beat.data[0];
      hv_q <= (len_nxt == ADDR_L) & grp_q;
      if (len_nxt == ADDR_L) hash_q <= addr_fcs[31 -: HASH_W];
      if (in_beat.last) begin
        crc_q <= CRC_PRESET;
        len_q <= '0;
      end else begin
        crc_q <= crc_nxt;
        len_q <= len_nxt;
      end
    end else begin
      beat_q <= '0;
      good_q <= 1'b0;
      drop_q <= 1'b0;
      hv_q   <= 1'b0;
    end
  end
endmodule

// File: rtl/lpbk_fcs_ctrl.sv
module lpbk_fcs_ctrl
  import lbk_pkg::*;
#(
  parameter int MIN_LEN    = 64,
  parameter int ADDR_BYTES = 6,
  parameter int HASH_W     = 6,
  parameter int LEN_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_lb_en,
  input  logic              cfg_lb_int,
  input  logic              cfg_lb_codec,
  input  logic              cfg_tx_fcs_dis,
  input  logic              cfg_runt_acc,
  input  logic              tx_valid,
  input  logic [7:0]        tx_data,
  input  logic              tx_last,
  output logic              tx_ready,
  output logic              net_tx_valid,
  output logic [7:0]        net_tx_data,
  output logic              net_tx_last,
  input  logic              net_rx_valid,
  input  logic [7:0]        net_rx_data,
  input  logic              net_rx_last,
  output logic              rx_valid,
  output logic [7:0]        rx_data,
  output logic              rx_last,
  output logic              rx_good,
  output logic              rx_drop,
  output logic              rx_runt_eff,
  output logic              lb_via_codec,
  output logic              mc_hash_valid,
  output logic [HASH_W-1:0] mc_hash
);
  beat_t tx_stage;
  beat_t net_tx_b;
  beat_t net_rx_b;
  beat_t rx_src;
  beat_t rx_out;
  logic  runt_eff;
  logic  txs_valid;
  logic  txs_last;
  logic  tx_accept;

  assign net_rx_b  = '{valid: net_rx_valid, data: net_rx_data, last: net_rx_last};
  assign txs_valid = tx_stage.valid;
  assign txs_last  = tx_stage.last;
  assign tx_accept = tx_valid & tx_ready;

  lbk_tx_fcs #(.FCS_N(FCS_BYTES)) u_tx (
    .clk(clk), .rst_n(rst_n), .fcs_dis(cfg_tx_fcs_dis),
    .in_valid(tx_valid), .in_data(tx_data), .in_last(tx_last),
    .in_ready(tx_ready), .out_beat(tx_stage)
  );

  lbk_path_sel u_path (
    .lb_en(cfg_lb_en), .lb_int(cfg_lb_int), .lb_codec(cfg_lb_codec),
    .runt_acc(cfg_runt_acc), .tx_beat(tx_stage), .net_rx_beat(net_rx_b),
    .net_tx_beat(net_tx_b), .rx_src_beat(rx_src), .runt_eff(runt_eff),
    .via_codec(lb_via_codec)
  );

  lbk_rx_chk #(.MIN_LEN(MIN_LEN), .ADDR_BYTES(ADDR_BYTES), .HASH_W(HASH_W),
               .LEN_W(LEN_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .in_beat(rx_src), .runt_eff(runt_eff),
    .out_beat(rx_out), .good(rx_good), .drop(rx_drop),
    .hash_valid(mc_hash_valid), .hash(mc_hash)
  );

  assign net_tx_valid = net_tx_b.valid;
  assign net_tx_data  = net_tx_b.data;
  assign net_tx_last  = net_tx_b.last;
  assign rx_valid     = rx_out.valid;
  assign rx_data      = rx_out.data;
  assign rx_last      = rx_out.last;
  assign rx_runt_eff  = runt_eff;
endmodule

// File: rtl/lpbk_fcs_chk.sv
module lpbk_fcs_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_lb_en,
  input logic cfg_lb_int,
  input logic cfg_tx_fcs_dis,
  input logic cfg_runt_acc,
  input logic tx_accept,
  input logic tx_last,
  input logic tx_ready,
  input logic txs_valid,
  input logic txs_last,
  input logic net_tx_valid,
  input logic rx_valid,
  input logic rx_last,
  input logic rx_good,
  input logic rx_drop,
  input logic mc_hash_valid
);
  p_ready_drops_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_accept && tx_last && !cfg_tx_fcs_dis) |=> !tx_ready);
  p_append_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_ready |-> txs_valid);
  p_ready_back_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_ready) |-> (txs_valid && txs_last));
  p_status_on_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_good || rx_drop) |-> (rx_valid && rx_last));
  p_drop_needs_no_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_drop |-> $past(!cfg_runt_acc && !cfg_lb_en));
  p_loop_reaches_rx_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_lb_en && cfg_lb_int && txs_valid) |=> rx_valid);
  p_ext_on_wire_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_lb_en && !cfg_lb_int && txs_valid) |-> net_tx_valid);
  p_hash_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mc_hash_valid |=> !mc_hash_valid);
endmodule

bind lpbk_fcs_ctrl lpbk_fcs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_lb_en(cfg_lb_en), .cfg_lb_int(cfg_lb_int),
  .cfg_tx_fcs_dis(cfg_tx_fcs_dis), .cfg_runt_acc(cfg_runt_acc),
  .tx_accept(tx_accept), .tx_last(tx_last), .tx_ready(tx_ready),
  .txs_valid(txs_valid), .txs_last(txs_last), .net_tx_valid(net_tx_valid),
  .rx_valid(rx_valid), .rx_last(rx_last), .rx_good(rx_good),
  .rx_drop(rx_drop), .mc_hash_valid(mc_hash_valid)
);

// File: tb/tb_lpbk_fcs_ctrl.sv
module tb_lpbk_fcs_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_lb_en = 0, cfg_lb_int = 0, cfg_lb_codec = 0;
  logic cfg_tx_fcs_dis = 0, cfg_runt_acc = 0;
  logic tx_valid = 0, tx_last = 0;
  logic [7:0] tx_data = 0;
  logic tx_ready;
  logic net_tx_valid, net_tx_last;
  logic [7:0] net_tx_data;
  logic net_rx_valid = 0, net_rx_last = 0;
  logic [7:0] net_rx_data = 0;
  logic rx_valid, rx_last, rx_good, rx_drop, rx_runt_eff, lb_via_codec;
  logic [7:0] rx_data;
  logic mc_hash_valid;
  logic [5:0] mc_hash;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lpbk_fcs_ctrl dut (.*);

  // Monitors: gather what the outputs deliver
  logic [7:0] net_got[$];
  logic [7:0] rx_got[$];
  int rx_end = 0;
  int hash_cnt = 0;
  logic last_good = 0, last_drop = 0;
  logic [5:0] last_hash = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (net_tx_valid) net_got.push_back(net_tx_data);
      if (rx_valid) begin
        rx_got.push_back(rx_data);
        if (rx_last) begin
          rx_end++;
          last_good = rx_good;
          last_drop = rx_drop;
        end
      end
      if (mc_hash_valid) begin
        hash_cnt++;
        last_hash = mc_hash;
      end
      // per-cycle model of the status outputs (R5, R11)
      checks++;
      if (rx_runt_eff !== (cfg_runt_acc | cfg_lb_en)) begin
        errors++;
        $display("FAIL R5 rx_runt_eff act=%0b exp=%0b", rx_runt_eff, cfg_runt_acc | cfg_lb_en);
      end
      checks++;
      if (lb_via_codec !== (cfg_lb_en & cfg_lb_codec)) begin
        errors++;
        $display("FAIL R11 lb_via_codec act=%0b exp=%0b", lb_via_codec, cfg_lb_en & cfg_lb_codec);
      end
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // Reference CRC: MSB-first shift register fed with bit-reversed bytes
  function automatic logic [31:0] ref_fcs(input logic [7:0] f[$], input int n);
    logic [31:0] c = 32'hFFFFFFFF;
    logic [31:0] v;
    for (int k = 0; k < n; k++)
      for (int b = 0; b < 8; b++) begin
        logic fb;
        fb = c[31] ^ f[k][b];
        c = c << 1;
        if (fb) c = c ^ 32'h04C11DB7;
      end
    c = ~c;
    for (int b = 0; b < 32; b++) v[b] = c[31-b];
    return v;
  endfunction

  function automatic void add_fcs(ref logic [7:0] f[$]);
    logic [31:0] v;
    v = ref_fcs(f, f.size());
    for (int b = 0; b < 4; b++) f.push_back(v[8*b +: 8]);
  endfunction

  function automatic logic same(input logic [7:0] a[$], input logic [7:0] b[$]);
    if (a.size() != b.size()) return 1'b0;
    for (int k = 0; k < a.size(); k++) if (a[k] !== b[k]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic void mk(ref logic [7:0] f[$], input int n, input logic [7:0] first, input int seed);
    f.delete();
    f.push_back(first);
    for (int k = 1; k < n; k++) f.push_back(8'((k * 37 + seed * 11) ^ (k >> 2)));
  endfunction

  task automatic send_tx(input logic [7:0] f[$]);
    for (int k = 0; k < f.size(); k++) begin
      tx_valid = 1; tx_data = f[k]; tx_last = (k == f.size() - 1);
      while (!tx_ready) @(negedge clk);
      @(negedge clk);
    end
    tx_valid = 0; tx_last = 0;
  endtask

  task automatic send_rx(input logic [7:0] f[$]);
    for (int k = 0; k < f.size(); k++) begin
      net_rx_valid = 1; net_rx_data = f[k]; net_rx_last = (k == f.size() - 1);
      @(negedge clk);
    end
    net_rx_valid = 0; net_rx_last = 0;
  endtask

  task automatic clear();
    net_got.delete(); rx_got.delete(); rx_end = 0; hash_cnt = 0;
  endtask

  task automatic settle();
    repeat (10) @(negedge clk);
  endtask

  logic [7:0] fa[$];
  logic [7:0] fe[$];
  logic [7:0] fg[$];

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", {tx_ready, net_tx_valid, rx_valid, mc_hash_valid}, 4'b1000, "outputs in reset");
    rst_n = 1;
    @(negedge clk);
    chk("R1", {tx_ready, net_tx_valid, rx_valid, mc_hash_valid}, 4'b1000, "outputs after reset");

    // R2: normal mode, check bytes appended
    clear(); mk(fa, 20, 8'h02, 1); send_tx(fa); settle();
    fe = fa; add_fcs(fe);
    chk("R2", same(net_got, fe), 1, "tx frame with appended check");
    chk("R2", net_got.size(), 24, "tx frame length");

    // R3: append disabled, frame passes unchanged
    cfg_tx_fcs_dis = 1;
    clear(); mk(fa, 30, 8'h02, 2); add_fcs(fa); send_tx(fa); settle();
    chk("R3", same(net_got, fa), 1, "tx frame unchanged");
    chk("R3", net_got.size(), 34, "tx frame length");
    cfg_tx_fcs_dis = 0;

    // R4, R9: good 64-byte multicast frame from the wire
    clear(); mk(fa, 60, 8'h01, 3); fe = fa; add_fcs(fe); send_rx(fe); settle();
    chk("R4", {last_good, last_drop}, 2'b10, "good 64-byte frame");
    chk("R4", same(rx_got, fe), 1, "rx data");
    chk("R9", hash_cnt, 1, "hash pulses");
    chk("R9", last_hash, 6'(ref_fcs(fa, 6) >> 26), "hash value");

    // R4: corrupted frame
    clear(); fe[10] = fe[10] ^ 8'h40; send_rx(fe); settle();
    chk("R4", {rx_end[3:0], last_good}, 5'b00010, "bad frame flagged");

    // R5: short unicast frame, accept off then on
    clear(); mk(fa, 16, 8'h02, 4); add_fcs(fa); send_rx(fa); settle();
    chk("R5", {last_good, last_drop}, 2'b11, "short frame dropped");
    chk("R9", hash_cnt, 0, "no hash for unicast");
    cfg_runt_acc = 1;
    clear(); send_rx(fa); settle();
    chk("R5", {last_good, last_drop}, 2'b10, "short frame kept with accept");
    cfg_runt_acc = 0;

    // R6, R7: internal loopback with wire traffic present
    cfg_lb_en = 1; cfg_lb_int = 1; @(negedge clk);
    clear(); mk(fa, 10, 8'h02, 5); mk(fg, 40, 8'hAA, 6);
    fork send_tx(fa); send_rx(fg); join
    settle();
    fe = fa; add_fcs(fe);
    chk("R6", net_got.size(), 0, "no wire transmit");
    chk("R6", rx_end, 1, "only looped frame received");
    chk("R6", same(rx_got, fe), 1, "looped data");
    chk("R7", {last_good, last_drop}, 2'b10, "looped runt kept");

    // R10: single-byte frames through internal loopback
    clear(); mk(fa, 1, 8'h5C, 7); send_tx(fa); settle();
    fe = fa; add_fcs(fe);
    chk("R10", same(rx_got, fe), 1, "one byte plus check looped");
    chk("R10", last_good, 1, "one byte frame good");
    cfg_tx_fcs_dis = 1;
    clear(); send_tx(fa); settle();
    chk("R10", {rx_got.size() == 1, rx_end[3:0]}, 5'b10001, "one byte, no append");
    cfg_tx_fcs_dis = 0;

    // R8, R7: external loopback
    cfg_lb_int = 0; @(negedge clk);
    clear(); mk(fa, 12, 8'h02, 8); send_tx(fa); settle();
    fe = fa; add_fcs(fe);
    chk("R8", same(net_got, fe), 1, "external loop sends on wire");
    chk("R8", rx_end, 0, "receiver follows wire");
    clear(); send_rx(fe); settle();
    chk("R8", same(rx_got, fe), 1, "wire frame received");
    chk("R7", {last_good, last_drop}, 2'b10, "external runt kept");
    clear(); mk(fa, 1, 8'h33, 9); send_tx(fa); settle();
    chk("R10", net_got.size(), 5, "one byte on wire in external loop");

    // R11: coder-in-loop status
    cfg_lb_codec = 1; @(negedge clk);
    chk("R11", lb_via_codec, 1, "codec with loop");
    cfg_lb_en = 0; @(negedge clk);
    chk("R11", lb_via_codec, 0, "codec without loop");
    chk("R5", rx_runt_eff, 0, "accept follows stored bit");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule